// File: doc/BRIEF.md
# Image Sensor Frame Capture

This block takes the timing strobes and pixel bus of a CMOS image sensor and turns each frame into a stream of memory write requests. The sensor's start-of-frame, line-start and pixel-valid signals arrive aligned to the sensor's own master clock. The block brings them into the system clock domain through synchronizer stages and detects their edges. The pixel bus travels through a matching pipeline, so the value taken at a strobe edge is the one that was present when the strobe was first seen high.

A four-state controller walks through each frame: `ST_IDLE` → `ST_WAIT_LINE` → `ST_LINE_HIGH` → `ST_PIXELS`. The transitions are:

- **T_SOF**: a start-of-frame rise, taken from any state, goes to `ST_WAIT_LINE`.
- **T_LINE_UP**: a line-start rise goes from `ST_WAIT_LINE` to `ST_LINE_HIGH`.
- **T_LINE_DOWN**: a line-start fall goes from `ST_LINE_HIGH` to `ST_PIXELS`.
- **T_ROW_DONE**: the last pixel of a row that is not the final row goes from `ST_PIXELS` back to `ST_WAIT_LINE`.
- **T_FRAME_DONE**: the last pixel of the final row goes from `ST_PIXELS` to `ST_IDLE`.

Pixels are reduced to their upper eight bits and paired into 16-bit words. Each word is offered to a memory arbiter with a request/acknowledge handshake, at addresses that count up from a frame base.

Top module: `img_frame_capture`

## Requirements
- R1: After reset, `wr_req_o` and `overflow_o` are 0 and `row_o` and `col_o` are 0.
- R2: A rising edge on `sof_i` clears `row_o`, `col_o` and `overflow_o`. It discards any unpaired pixel and restarts word addresses at `BASE_ADDR`, including when it arrives in the middle of a frame.
- R3: A row's pixels are counted only after `line_i` has risen and then fallen again. Pixel-valid rises seen while `line_i` is high have no effect on written data.
- R4: Each counted pixel-valid rise captures `pix_i[9:2]`. The first pixel of a pair goes to `wr_data_o[7:0]` and the second to `wr_data_o[15:8]`.
- R5: Each completed pair produces one request, at `BASE_ADDR` for the first word of a frame and one higher for each word after it. A full frame yields COLS×ROWS/2 writes.
- R6: While `wr_req_o` is high and `wr_ack_i` is low, the request, `wr_addr_o` and `wr_data_o` hold their values into the next cycle. A word counts as accepted at a clock edge where both are high.
- R7: `col_o` counts the pixels of the current row up to COLS. `row_o` counts completed rows up to ROWS. After a full frame they read ROWS and COLS, and further pixel-valid rises are ignored until the next start-of-frame rise.
- R8: A counted pixel that arrives while a request is pending and not acknowledged in that same cycle sets `overflow_o`, which stays set until the next start-of-frame rise. A pair completed under that condition is dropped. An acknowledge in the same cycle as the pixel counts as acceptance and raises no overflow.
- R9: Pixel-valid rises after the COLS-th pixel of a row, before the next line-start, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof_i | input | 1 | Sensor start-of-frame level |
| line_i | input | 1 | Sensor line-start level |
| pix_vld_i | input | 1 | Sensor pixel-valid strobe |
| pix_i | input | PIX_W (10) | Sensor pixel value |
| wr_ack_i | input | 1 | Arbiter accepts the current request |
| wr_req_o | output | 1 | Write request to the arbiter |
| wr_addr_o | output | ADDR_W (23) | Word address of the request |
| wr_data_o | output | 2×BYTE_W (16) | Packed pixel pair |
| overflow_o | output | 1 | Sticky lost-pixel flag |
| row_o | output | ROW_W | Completed rows in this frame |
| col_o | output | COL_W | Pixels counted in the current row |

## Verification
Two functions can land on the same clock edge: the arbiter accepting the pending word, and the capture of the next pixel, which may complete a new pair. The bench provokes this by choosing the acknowledge latency of each request at random from 0 to 7 cycles, with pixels eight cycles apart. One whole frame forces latency 7, so that every acceptance coincides with the next pixel capture. It judges the outcome by checking that every word arrives in order at the expected address with the expected data, and that `overflow_o` stays low. A separate frame withholds acknowledge entirely, to confirm that the flag rises and that only the first word is written.

// File: rtl/fc_pkg.sv
package fc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_LINE,
        ST_LINE_HIGH,
        ST_PIXELS
    } cap_state_t;

endpackage

// File: rtl/fc_sync.sv
module fc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/fc_ctrl.sv
module fc_ctrl
    import fc_pkg::*;
#(
    parameter int COLS  = 128,
    parameter int ROWS  = 10,
    parameter int COL_W = $clog2(COLS + 1),
    parameter int ROW_W = $clog2(ROWS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof_s,
    input  logic             line_s,
    input  logic             vld_s,
    output logic             sof_rise,
    output logic             take,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col
);

    localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    cap_state_t state_q, state_d;
    logic sof_p, line_p, vld_p;
    logic line_rise, line_fall, vld_rise;
    logic row_start, row_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sof_p  <= 1'b0;
            line_p <= 1'b0;
            vld_p  <= 1'b0;
        end else begin
            sof_p  <= sof_s;
            line_p <= line_s;
            vld_p  <= vld_s;
        end
    end

    assign sof_rise  = sof_s & ~sof_p;
    assign line_rise = line_s & ~line_p;
    assign line_fall = ~line_s & line_p;
    assign vld_rise  = vld_s & ~vld_p;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output decode
    always_comb begin
        take      = 1'b0;
        row_start = 1'b0;
        unique case (state_q)
            ST_IDLE:      ;
            ST_WAIT_LINE: row_start = line_rise & ~sof_rise;
            ST_LINE_HIGH: ;
            ST_PIXELS:    take = vld_rise & ~sof_rise;
        endcase
        row_end = take & (col == LAST_COL);
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        if (sof_rise) begin
            state_d = ST_WAIT_LINE;                       // T_SOF
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_WAIT_LINE: if (line_rise) state_d = ST_LINE_HIGH;   // T_LINE_UP
                ST_LINE_HIGH: if (line_fall) state_d = ST_PIXELS;      // T_LINE_DOWN
                ST_PIXELS:    if (row_end)
                                  state_d = (row == LAST_ROW) ? ST_IDLE       // T_FRAME_DONE
                                                              : ST_WAIT_LINE; // T_ROW_DONE
            endcase
        end
    end

    // Row and column counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row <= '0;
            col <= '0;
        end else if (sof_rise) begin
            row <= '0;
            col <= '0;
        end else if (row_start) begin
            col <= '0;
        end else if (take) begin
            col <= col + 1'b1;
            if (row_end) row <= row + 1'b1;
        end
    end

endmodule

// File: rtl/fc_packer.sv
module fc_packer #(
    parameter int BYTE_W    = 8,
    parameter int ADDR_W    = 23,
    parameter int BASE_ADDR = 0,
    parameter int WORD_W    = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              take,
    input  logic [BYTE_W-1:0] pix_byte,
    input  logic              ack,
    output logic              req,
    output logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] data,
    output logic              ovf
);

    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

    logic [BYTE_W-1:0] lo_q;
    logic              half_q;
    logic [ADDR_W-1:0] nxt_q;
    logic              stalled;

    assign stalled = req & ~ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req    <= 1'b0;
            addr   <= BASE;
            data   <= '0;
            ovf    <= 1'b0;
            lo_q   <= '0;
            half_q <= 1'b0;
            nxt_q  <= BASE;
        end else begin
            if (req && ack) req <= 1'b0;
            if (clr) begin
                half_q <= 1'b0;
                nxt_q  <= BASE;
                ovf    <= 1'b0;
            end else if (take) begin
                if (stalled) ovf <= 1'b1;
                if (!half_q) begin
                    lo_q   <= pix_byte;
                    half_q <= 1'b1;
                end else begin
                    half_q <= 1'b0;
                    if (!stalled) begin
                        req   <= 1'b1;
                        data  <= {pix_byte, lo_q};
                        addr  <= nxt_q;
                        nxt_q <= nxt_q + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/img_frame_capture.sv
module img_frame_capture #(
    parameter int PIX_W       = 10,
    parameter int BYTE_W      = 8,
    parameter int ADDR_W      = 23,
    parameter int BASE_ADDR   = 0,
    parameter int COLS        = 128,
    parameter int ROWS        = 10,
    parameter int SYNC_STAGES = 2,
    parameter int COL_W       = $clog2(COLS + 1),
    parameter int ROW_W       = $clog2(ROWS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sof_i,
    input  logic                line_i,
    input  logic                pix_vld_i,
    input  logic [PIX_W-1:0]    pix_i,
    input  logic                wr_ack_i,
    output logic                wr_req_o,
    output logic [ADDR_W-1:0]   wr_addr_o,
    output logic [2*BYTE_W-1:0] wr_data_o,
    output logic                overflow_o,
    output logic [ROW_W-1:0]    row_o,
    output logic [COL_W-1:0]    col_o
);

    localparam int SYNC_W = 3 + BYTE_W;

    logic [SYNC_W-1:0] sync_in, sync_out;
    logic              sof_s, line_s, vld_s;
    logic [BYTE_W-1:0] byte_s;
    logic              sof_rise, take;
    logic              unused_low_bits;

    assign sync_in = {pix_i[PIX_W-1 -: BYTE_W], pix_vld_i, line_i, sof_i};
    assign unused_low_bits = ^pix_i[PIX_W-BYTE_W-1:0];

    fc_sync #(
        .W      (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sync_in),
        .q     (sync_out)
    );

    assign {byte_s, vld_s, line_s, sof_s} = sync_out;

    fc_ctrl #(
        .COLS  (COLS),
        .ROWS  (ROWS),
        .COL_W (COL_W),
        .ROW_W (ROW_W)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sof_s    (sof_s),
        .line_s   (line_s),
        .vld_s    (vld_s),
        .sof_rise (sof_rise),
        .take     (take),
        .row      (row_o),
        .col      (col_o)
    );

    fc_packer #(
        .BYTE_W    (BYTE_W),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) pack_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sof_rise),
        .take     (take),
        .pix_byte (byte_s),
        .ack      (wr_ack_i),
        .req      (wr_req_o),
        .addr     (wr_addr_o),
        .data     (wr_data_o),
        .ovf      (overflow_o)
    );

endmodule

// File: rtl/fc_checker.sv
module fc_checker #(
    parameter int ADDR_W = 23,
    parameter int WORD_W = 16,
    parameter int COLS   = 128,
    parameter int ROWS   = 10,
    parameter int COL_W  = 8,
    parameter int ROW_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              req,
    input logic              ack,
    input logic [ADDR_W-1:0] addr,
    input logic [WORD_W-1:0] data,
    input logic              ovf,
    input logic [ROW_W-1:0]  row,
    input logic [COL_W-1:0]  col
);

    // R6: a stalled request keeps its address and data
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> (req && $stable(addr) && $stable(data)));

    // R7: counters stay within the frame geometry
    p_col_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        col <= COL_W'(COLS));

    p_row_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        row <= ROW_W'(ROWS));

    // R8: overflow is sticky until a start-of-frame rise
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf);

    // R8: overflow rises only while a request was stalled
    p_ovf_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(req && !ack));

    // R2: start-of-frame clears the overflow flag
    p_ovf_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !ovf);

endmodule

bind img_frame_capture fc_checker #(
    .ADDR_W (ADDR_W),
    .WORD_W (2 * BYTE_W),
    .COLS   (COLS),
    .ROWS   (ROWS),
    .COL_W  (COL_W),
    .ROW_W  (ROW_W)
) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (sof_rise),
    .req   (wr_req_o),
    .ack   (wr_ack_i),
    .addr  (wr_addr_o),
    .data  (wr_data_o),
    .ovf   (overflow_o),
    .row   (row_o),
    .col   (col_o)
);

// File: tb/img_frame_capture_tb_top.sv
module img_frame_capture_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PIX_W      = 10;
    localparam int ADDR_W     = 12;
    localparam int BASE       = 'h100;
    localparam int COLS       = 8;
    localparam int ROWS       = 3;
    localparam int COL_W      = $clog2(COLS + 1);
    localparam int ROW_W      = $clog2(ROWS + 1);
    localparam int MCLK       = 8;
    localparam int WATCHDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sof = 1'b0, line = 1'b0, vld = 1'b0, ack = 1'b0;
    logic [PIX_W-1:0]  pix = '0;
    logic              req, ovf;
    logic [ADDR_W-1:0] addr;
    logic [15:0]       data;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench model
    logic [ADDR_W+15:0] exp_q [$];
    logic [7:0] m_lo;
    bit         m_half;
    int         m_addr;
    int         m_wcount;
    bit         m_stall = 1'b0;
    bit         ack_en  = 1'b1;
    bit         force7  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    img_frame_capture #(
        .PIX_W     (PIX_W),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE),
        .COLS      (COLS),
        .ROWS      (ROWS)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof_i      (sof),
        .line_i     (line),
        .pix_vld_i  (vld),
        .pix_i      (pix),
        .wr_ack_i   (ack),
        .wr_req_o   (req),
        .wr_addr_o  (addr),
        .wr_data_o  (data),
        .overflow_o (ovf),
        .row_o      (row),
        .col_o      (col)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pack_word(logic [7:0] first, logic [7:0] second);
        return {second, first};
    endfunction

    function automatic void model_sof();
        m_half   = 1'b0;
        m_addr   = BASE;
        m_wcount = 0;
    endfunction

    function automatic void model_pix(logic [PIX_W-1:0] p);
        if (!m_half) begin
            m_lo   = p[9:2];
            m_half = 1'b1;
        end else begin
            m_half = 1'b0;
            if (!(m_stall && m_wcount > 0)) begin
                exp_q.push_back({ADDR_W'(m_addr), pack_word(m_lo, p[9:2])});
                m_addr++;
            end
            m_wcount++;
        end
    endfunction

    // Arbiter model and write monitor (R4, R5, R6, R8 same-cycle case)
    initial begin
        int wait_cnt = 0;
        int lat = 0;
        forever begin
            @(negedge clk);
            if (req && ack_en) begin
                if (wait_cnt >= lat) begin
                    logic [ADDR_W+15:0] e;
                    ack = 1'b1;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R5", "unexpected write addr", addr, 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(addr == e[ADDR_W+15:16], "R5", "write address", addr, e[ADDR_W+15:16]);
                        chk(data == e[15:0], "R4", "write data", data, e[15:0]);
                    end
                    wait_cnt = 0;
                    lat = force7 ? 7 : $urandom_range(7, 0);
                end else begin
                    ack = 1'b0;
                    wait_cnt++;
                end
            end else begin
                ack = 1'b0;
            end
        end
    end

    task automatic mclk_wait(input int n);
        repeat (n * MCLK) @(negedge clk);
    endtask

    task automatic send_pix(input bit counted);
        logic [PIX_W-1:0] p;
        p = PIX_W'($urandom);
        @(negedge clk);
        pix = p;
        repeat (MCLK/2 - 1) @(negedge clk);
        vld = 1'b1;
        if (counted) model_pix(p);
        repeat (MCLK/2) @(negedge clk);
        vld = 1'b0;
    endtask

    // nrows rows; last row carries last_cols pixels; inject adds ignored strobes
    task automatic send_frame(input int nrows, input int last_cols, input bit inject);
        @(negedge clk);
        sof = 1'b1;
        model_sof();
        mclk_wait(8);
        for (int r = 0; r < nrows; r++) begin
            line = 1'b1;
            if (inject && r == 0) begin
                mclk_wait(32);
                send_pix(1'b0);                    // R3 strobe while line-start high
                mclk_wait(31);
            end else begin
                mclk_wait(64);
            end
            line = 1'b0;
            for (int c = 0; c < ((r == nrows - 1) ? last_cols : COLS); c++)
                send_pix(1'b1);
            if (inject && last_cols == COLS) send_pix(1'b0);  // R9 extra strobe
            if (r == 0) sof = 1'b0;
        end
        mclk_wait(64);
    endtask

    // watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R5 watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_sof();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req == 1'b0, "R1", "req after reset", req, 0);
        chk(ovf == 1'b0, "R1", "overflow after reset", ovf, 0);
        chk(row == '0, "R1", "row after reset", row, 0);
        chk(col == '0, "R1", "col after reset", col, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // full frame with ignored strobes (R3, R9), then R7 end state
        send_frame(ROWS, COLS, 1'b1);
        chk(exp_q.size() == 0, "R5", "words left after frame 1", exp_q.size(), 0);
        chk(row == ROW_W'(ROWS), "R7", "row at frame end", row, ROWS);
        chk(col == COL_W'(COLS), "R7", "col at frame end", col, COLS);
        chk(ovf == 1'b0, "R8", "no overflow with timely ack", ovf, 0);

        // R7 strobe after frame end is ignored
        send_pix(1'b0);
        repeat (20) @(negedge clk);
        chk(col == COL_W'(COLS), "R7", "col after post-frame strobe", col, COLS);
        chk(req == 1'b0, "R7", "no request after post-frame strobe", req, 0);

        // second random frame
        send_frame(ROWS, COLS, 1'b0);
        chk(exp_q.size() == 0, "R5", "words left after frame 2", exp_q.size(), 0);

        // acceptance coinciding with every next pixel capture (R8)
        force7 = 1'b1;
        send_frame(ROWS, COLS, 1'b0);
        force7 = 1'b0;
        chk(exp_q.size() == 0, "R8", "words left after latency-7 frame", exp_q.size(), 0);
        chk(ovf == 1'b0, "R8", "no overflow on same-cycle ack", ovf, 0);

        // aborted frame then restart (R2)
        send_frame(2, 3, 1'b0);
        chk(row == ROW_W'(1), "R7", "row in partial frame", row, 1);
        chk(col == COL_W'(3), "R7", "col in partial frame", col, 3);
        chk(exp_q.size() == 0, "R5", "words left after partial frame", exp_q.size(), 0);
        send_frame(ROWS, COLS, 1'b0);
        chk(exp_q.size() == 0, "R2", "restart frame from base", exp_q.size(), 0);

        // overflow frame (R8)
        ack_en  = 1'b0;
        m_stall = 1'b1;
        send_frame(ROWS, COLS, 1'b0);
        chk(ovf == 1'b1, "R8", "overflow set when ack withheld", ovf, 1);
        chk(req == 1'b1, "R6", "request held while stalled", req, 1);
        chk(exp_q.size() == 1, "R8", "only first word pending", exp_q.size(), 1);
        m_stall = 1'b0;
        ack_en  = 1'b1;
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R8", "first word written after stall", exp_q.size(), 0);
        chk(req == 1'b0, "R8", "dropped words not requested", req, 0);
        chk(ovf == 1'b1, "R8", "overflow stays sticky", ovf, 1);

        // start-of-frame clears overflow (R2)
        @(negedge clk);
        sof = 1'b1;
        model_sof();
        repeat (6) @(negedge clk);
        chk(ovf == 1'b0, "R2", "overflow cleared by start-of-frame", ovf, 0);
        chk(row == '0 && col == '0, "R2", "counters cleared by start-of-frame", {row, col}, 0);
        sof = 1'b0;
        mclk_wait(4);
        send_frame(ROWS, COLS, 1'b0);
        chk(exp_q.size() == 0, "R5", "words left after final frame", exp_q.size(), 0);
        chk(ovf == 1'b0, "R8", "no overflow in final frame", ovf, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule